// File: doc/BRIEF.md
# UART Modem Status and Interrupt Enable Unit

This block holds the modem-status register and the interrupt-enable register of a UART. It watches four modem-control lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It raises sticky change flags that clear when software reads the status register. It shows the inverted clear-to-send level. It stores per-source interrupt enables and a sleep enable. In loopback the four lines come from the modem-control register bits, not from the pins.

The interrupt output is raised while any enabled source is pending. Two event pulses, RTS change and XOFF received, come from neighbouring logic. The block latches each pulse until the status register is read. When sleep is enabled and the line reports idle, a registered output asks the baud generator to stop its clock.

Top module: `uart_msr_ier`

## Requirements
- R1: Status bit 4 reads as the inverse of the synchronized `cts_pin` level in normal mode, and as `mcr_bits[1]` in loopback. Status bits 7:5 read as 0.
- R2: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) each set on any change of their source line, in either direction.
- R3: Status bit 2 (RI) sets only when its source goes from 0 to 1. A falling edge leaves it unchanged.
- R4: While `loop_en` is 1, the sources are taken from the modem-control bits: CTS from `mcr_bits[1]`, DSR from `mcr_bits[0]`, RI from `mcr_bits[2]` and DCD from `mcr_bits[3]`. Pin activity has no effect.
- R5: A read at address 6 returns the status byte on `bus_rdata` one cycle later and clears bits 3:0. An event in the same cycle as that read leaves its flag set for the next read.
- R6: The enable register sits at address 1 and is reachable only while `div_latch` is 0. While `div_latch` is 1, writes are ignored and reads return 0.
- R7: Enable bits 3:0 take every write. Bits 7:4 change only when `ext_feat_en` is 1; otherwise they keep their old value.
- R8: After reset the enable register, the status flags, `irq` and `baud_stop` are all 0.
- R9: `irq` is 1 in the same cycle that a source becomes pending, and stays 1 while it is pending. The sources are: enable bit 7 with the CTS flag, bit 3 with any of flags 3:0, bit 6 with a latched `rts_evt` pulse, and bit 5 with a latched `xoff_evt` pulse. The latches are cleared by a status read.
- R10: `baud_stop` equals enable bit 4 AND `line_idle`, delayed by one register.
- R11: Pin changes pass through a two-stage synchronizer. A pin change driven before clock edge k sets its flag at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cts_pin | input | 1 | Clear-to-send line |
| dsr_pin | input | 1 | Data-set-ready line |
| ri_pin | input | 1 | Ring indicator line |
| dcd_pin | input | 1 | Carrier detect line |
| loop_en | input | 1 | Loopback mode |
| mcr_bits | input | 4 | Modem-control register bits |
| ext_feat_en | input | 1 | Unlocks enable bits 7:4 |
| div_latch | input | 1 | Divisor-latch access, hides the enable register |
| rts_evt | input | 1 | RTS change event pulse |
| xoff_evt | input | 1 | XOFF received event pulse |
| line_idle | input | 1 | Serializer reports no activity |
| irq | output | 1 | Interrupt request |
| baud_stop | output | 1 | Request to stop the baud clock |

## Verification
The bench sweeps every 0-to-1 pair of source patterns, both in loopback and through the pins. A design that set the RI flag on a falling edge, or that mixed up the mapping from control bits to sources, would miscompare on one of those pairs. It sweeps all enable write values under every combination of the feature unlock and the divisor-latch bit, which exposes a leaking upper nibble or writes that get through a hidden register. It drives an event in the same cycle as a status read: a design that let the clear win would lose that flag. It measures pin-to-interrupt latency, which shows a missing or extra synchronizer stage.

// File: rtl/uart_mi_pkg.sv
package uart_mi_pkg;
  localparam int SRC_N    = 4;
  localparam int IDX_CTS  = 0;
  localparam int IDX_DSR  = 1;
  localparam int IDX_RI   = 2;
  localparam int IDX_DCD  = 3;
  localparam int EN_MSC   = 3;
  localparam int EN_SLEEP = 4;
  localparam int EN_XOFF  = 5;
  localparam int EN_RTS   = 6;
  localparam int EN_CTS   = 7;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/uart_mi_sync.sv
module uart_mi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_mi_status.sv
module uart_mi_status
  import uart_mi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t pins_sync,
  input  logic     loop_en,
  input  logic [3:0] mcr_bits,
  input  logic     clr,
  output src_vec_t flags_q,
  output src_vec_t flags_d,
  output logic     cts_level
);
  src_vec_t loop_src, src, prev_q, evt;

  // loopback wiring of control bits onto the four sources
  assign loop_src[IDX_CTS] = mcr_bits[1];
  assign loop_src[IDX_DSR] = mcr_bits[0];
  assign loop_src[IDX_RI]  = mcr_bits[2];
  assign loop_src[IDX_DCD] = mcr_bits[3];

  assign src = loop_en ? loop_src : pins_sync;

  for (genvar i = 0; i < SRC_N; i++) begin : g_edge
    if (i == IDX_RI) begin : g_rise
      assign evt[i] = src[i] & ~prev_q[i];
    end else begin : g_any
      assign evt[i] = src[i] ^ prev_q[i];
    end
  end

  assign flags_d   = (flags_q & ~{SRC_N{clr}}) | evt;
  assign cts_level = loop_en ? mcr_bits[1] : ~pins_sync[IDX_CTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= src;
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/uart_mi_enable.sv
module uart_mi_enable #(
  parameter int DW = 8,
  parameter int LOCK_LSB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic          unlock,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] en_d
);
  always_comb begin
    en_d = en_q;
    if (wr_hit) begin
      en_d[LOCK_LSB-1:0] = wdata[LOCK_LSB-1:0];
      if (unlock) en_d[DW-1:LOCK_LSB] = wdata[DW-1:LOCK_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/uart_mi_evt.sv
module uart_mi_evt #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse,
  input  logic         clr,
  output logic [N-1:0] pend_d
);
  logic [N-1:0] pend_q;

  assign pend_d = (pend_q & ~{N{clr}}) | pulse;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/uart_msr_ier.sv
module uart_msr_ier
  import uart_mi_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DW          = 8,
  parameter int EN_ADDR     = 1,
  parameter int STAT_ADDR   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cts_pin,
  input  logic              dsr_pin,
  input  logic              ri_pin,
  input  logic              dcd_pin,
  input  logic              loop_en,
  input  logic [3:0]        mcr_bits,
  input  logic              ext_feat_en,
  input  logic              div_latch,
  input  logic              rts_evt,
  input  logic              xoff_evt,
  input  logic              line_idle,
  output logic              irq,
  output logic              baud_stop
);
  localparam int EVT_N = 2;

  src_vec_t     pins_raw, pins_sync, chg_flags, flags_d;
  logic         cts_level, stat_rd, en_wr, en_rd;
  logic [DW-1:0] ier_q, ier_d, stat_byte;
  logic [EVT_N-1:0] pend_d;
  logic         irq_d;

  assign pins_raw[IDX_CTS] = cts_pin;
  assign pins_raw[IDX_DSR] = dsr_pin;
  assign pins_raw[IDX_RI]  = ri_pin;
  assign pins_raw[IDX_DCD] = dcd_pin;

  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
  assign en_wr   = bus_wr && (bus_addr == ADDR_W'(EN_ADDR)) && !div_latch;
  assign en_rd   = bus_rd && (bus_addr == ADDR_W'(EN_ADDR)) && !div_latch;

  uart_mi_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_sync)
  );

  uart_mi_status i_status (
    .clk(clk), .rst(rst), .pins_sync(pins_sync), .loop_en(loop_en),
    .mcr_bits(mcr_bits), .clr(stat_rd), .flags_q(chg_flags),
    .flags_d(flags_d), .cts_level(cts_level)
  );

  uart_mi_enable #(.DW(DW), .LOCK_LSB(EN_SLEEP)) i_enable (
    .clk(clk), .rst(rst), .wr_hit(en_wr), .unlock(ext_feat_en),
    .wdata(bus_wdata), .en_q(ier_q), .en_d(ier_d)
  );

  uart_mi_evt #(.N(EVT_N)) i_evt (
    .clk(clk), .rst(rst), .pulse({xoff_evt, rts_evt}), .clr(stat_rd),
    .pend_d(pend_d)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[SRC_N-1:0] = chg_flags;
    stat_byte[SRC_N]     = cts_level;
  end

  assign irq_d = (ier_d[EN_MSC]  && (|flags_d))
              || (ier_d[EN_CTS]  && flags_d[IDX_CTS])
              || (ier_d[EN_RTS]  && pend_d[0])
              || (ier_d[EN_XOFF] && pend_d[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
      baud_stop <= 1'b0;
    end else begin
      irq       <= irq_d;
      baud_stop <= ier_q[EN_SLEEP] && line_idle;
      if (stat_rd)     bus_rdata <= stat_byte;
      else if (en_rd)  bus_rdata <= ier_q;
      else if (bus_rd) bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/uart_msr_ier_checker.sv
module uart_msr_ier_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       loop_en,
  input logic [3:0] mcr_bits,
  input logic       ext_feat_en,
  input logic       div_latch,
  input logic       irq,
  input logic       baud_stop,
  input logic [7:0] ier_q,
  input logic [3:0] chg_flags
);
  AST_UPPER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd1 && !div_latch && !ext_feat_en) |=> $stable(ier_q[7:4])); // R7
  AST_DL_GATE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && div_latch) |=> $stable(ier_q)); // R6
  AST_DL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd1 && div_latch) |=> (bus_rdata == 8'h00)); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (ier_q[7:5] == 3'b000 && !ier_q[3]) |-> !irq); // R9
  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    baud_stop |-> $past(ier_q[4])); // R10
  AST_LOOP_CTS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd6 && loop_en) |=> (bus_rdata[4] == $past(mcr_bits[1]))); // R1
  AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd6) |=> (bus_rdata[7:5] == 3'b000)); // R1
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd6 && loop_en && $past(loop_en) && !$past(rst)
     && mcr_bits == $past(mcr_bits)) |=> (chg_flags == 4'h0)); // R5
endmodule

bind uart_msr_ier uart_msr_ier_checker i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .loop_en(loop_en), .mcr_bits(mcr_bits),
  .ext_feat_en(ext_feat_en), .div_latch(div_latch), .irq(irq),
  .baud_stop(baud_stop), .ier_q(ier_q), .chg_flags(chg_flags)
);

// File: tb/test_uart_msr_ier.sv
module test_uart_msr_ier;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cts_pin = 1'b0, dsr_pin = 1'b0, ri_pin = 1'b0, dcd_pin = 1'b0;
  logic       loop_en = 1'b0;
  logic [3:0] mcr_bits = '0;
  logic       ext_feat_en = 1'b0, div_latch = 1'b0;
  logic       rts_evt = 1'b0, xoff_evt = 1'b0, line_idle = 1'b0;
  logic       irq, baud_stop;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  uart_msr_ier i_uart_msr_ier (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cts_pin(cts_pin),
    .dsr_pin(dsr_pin), .ri_pin(ri_pin), .dcd_pin(dcd_pin), .loop_en(loop_en),
    .mcr_bits(mcr_bits), .ext_feat_en(ext_feat_en), .div_latch(div_latch),
    .rts_evt(rts_evt), .xoff_evt(xoff_evt), .line_idle(line_idle),
    .irq(irq), .baud_stop(baud_stop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // flags in status-bit order {dcd, ri, dsr, cts} from source levels {dcd,ri,dsr,cts}
  function automatic logic [3:0] exp_flags(input logic [3:0] p, input logic [3:0] n);
    exp_flags[0] = p[0] ^ n[0];
    exp_flags[1] = p[1] ^ n[1];
    exp_flags[2] = ~p[2] & n[2];
    exp_flags[3] = p[3] ^ n[3];
  endfunction

  // control-bit pattern that drives sources {dcd,ri,dsr,cts}
  function automatic logic [3:0] to_mcr(input logic [3:0] s);
    to_mcr = {s[3], s[2], s[0], s[1]};
  endfunction

  task automatic set_pins(input logic [3:0] s);
    {dcd_pin, ri_pin, dsr_pin, cts_pin} = s;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp_ier;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    chk(irq == 1'b0, "R8 irq", irq, 0);
    chk(baud_stop == 1'b0, "R8 baud_stop", baud_stop, 0);
    rd_reg(3'd1, d);
    chk(d == 8'h00, "R8 enable reset", d, 0);
    rd_reg(3'd6, d);
    chk(d == 8'h10, "R8 R1 status reset (cts pin low)", d, 8'h10);

    // R6 R7 enable sweep
    exp_ier = 8'h00;
    for (int dl = 0; dl < 2; dl++) begin
      for (int ef = 0; ef < 2; ef++) begin
        for (int v = 0; v < 256; v++) begin
          div_latch = dl[0]; ext_feat_en = ef[0];
          wr_reg(3'd1, v[7:0]);
          if (dl == 0) begin
            exp_ier[3:0] = v[3:0];
            if (ef == 1) exp_ier[7:4] = v[7:4];
          end
          rd_reg(3'd1, d);
          if (dl == 1) chk(d == 8'h00, "R6 hidden read", d, 0);
          else         chk(d == exp_ier, "R7 enable write", d, exp_ier);
        end
      end
    end
    div_latch = 1'b0;
    rd_reg(3'd1, d);
    chk(d == exp_ier, "R6 value kept across hidden writes", d, exp_ier);
    ext_feat_en = 1'b1;
    wr_reg(3'd1, 8'h00);

    // R2 R3 R4 loopback pair sweep, pins toggled in opposition
    loop_en = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        @(negedge clk);
        mcr_bits = to_mcr(p[3:0]);
        rd_reg(3'd6, d);
        @(negedge clk);
        mcr_bits = to_mcr(n[3:0]);
        set_pins(~n[3:0]);
        repeat (3) @(negedge clk);
        rd_reg(3'd6, d);
        chk(d == {3'b000, to_mcr(n[3:0])[1], exp_flags(p[3:0], n[3:0])},
            "R2 R3 R4 loopback status", d,
            {3'b000, to_mcr(n[3:0])[1], exp_flags(p[3:0], n[3:0])});
      end
    end

    // R1 R2 R3 pin pair sweep, control bits toggled in opposition
    loop_en = 1'b0;
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        @(negedge clk);
        set_pins(p[3:0]);
        repeat (4) @(negedge clk);
        rd_reg(3'd6, d);
        @(negedge clk);
        set_pins(n[3:0]);
        mcr_bits = ~mcr_bits;
        repeat (4) @(negedge clk);
        rd_reg(3'd6, d);
        chk(d == {3'b000, ~n[0], exp_flags(p[3:0], n[3:0])},
            "R1 R2 R3 pin status", d, {3'b000, ~n[0], exp_flags(p[3:0], n[3:0])});
      end
    end

    // R11 pin latency through synchronizer, seen on irq
    set_pins(4'h0);
    repeat (4) @(negedge clk);
    rd_reg(3'd6, d);
    wr_reg(3'd1, 8'h80);
    cts_pin = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R11 after edge k", irq, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R11 after edge k+1", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 R9 after edge k+2", irq, 1);
    rd_reg(3'd6, d);
    chk(irq == 1'b0, "R9 cleared by status read", irq, 0);

    // R5 event in the same cycle as a status read
    loop_en = 1'b1; mcr_bits = 4'h0;
    repeat (2) @(negedge clk);
    rd_reg(3'd6, d);
    @(negedge clk);
    bus_addr = 3'd6; bus_rd = 1'b1; mcr_bits = 4'h1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata[3:0] == 4'h0, "R5 read before event", bus_rdata, 0);
    rd_reg(3'd6, d);
    chk(d[3:0] == 4'h2, "R5 event survives same-cycle read", d, 8'h02);
    rd_reg(3'd6, d);
    chk(d[3:0] == 4'h0, "R5 flag cleared after read", d, 0);

    // R9 modem-status enable with DSR change
    wr_reg(3'd1, 8'h08);
    @(negedge clk);
    mcr_bits = 4'h0;
    @(negedge clk);
    chk(irq == 1'b1, "R9 modem enable", irq, 1);
    rd_reg(3'd6, d);
    chk(irq == 1'b0, "R9 modem cleared", irq, 0);

    // R9 RTS and XOFF event latches
    wr_reg(3'd1, 8'h40);
    @(negedge clk); xoff_evt = 1'b1;
    @(negedge clk); xoff_evt = 1'b0;
    chk(irq == 1'b0, "R9 xoff masked", irq, 0);
    @(negedge clk); rts_evt = 1'b1;
    @(negedge clk); rts_evt = 1'b0;
    chk(irq == 1'b1, "R9 rts latched", irq, 1);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 rts held", irq, 1);
    rd_reg(3'd6, d);
    chk(irq == 1'b0, "R9 rts acknowledged", irq, 0);
    wr_reg(3'd1, 8'h20);
    @(negedge clk);
    chk(irq == 1'b0, "R9 xoff latch cleared by read", irq, 0);
    @(negedge clk); xoff_evt = 1'b1;
    @(negedge clk); xoff_evt = 1'b0;
    chk(irq == 1'b1, "R9 xoff latched", irq, 1);
    rd_reg(3'd6, d);
    chk(irq == 1'b0, "R9 xoff acknowledged", irq, 0);

    // R10 sleep request
    line_idle = 1'b1;
    wr_reg(3'd1, 8'h00);
    repeat (2) @(negedge clk);
    chk(baud_stop == 1'b0, "R10 sleep disabled", baud_stop, 0);
    wr_reg(3'd1, 8'h10);
    @(negedge clk);
    chk(baud_stop == 1'b1, "R10 sleep idle", baud_stop, 1);
    line_idle = 1'b0;
    @(negedge clk);
    chk(baud_stop == 1'b0, "R10 sleep busy", baud_stop, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule